// File: doc/BRIEF.md
# Carrier Phase Oscillator with Strobed Update

This block is the carrier oscillator of one receiver channel. It keeps a phase accumulator that is advanced by a signed frequency word. The advance happens only on an update strobe, which the block derives by dividing the system clock by a fixed ratio. With the default ratio of 62 and a 16.368 MHz clock, the strobe runs at about 264 kHz. One unit of the frequency word then equals the strobe rate divided by 2^PHASE_W, which is close to 1.007 Hz at the default width. The extreme positive word gives just under +half the strobe rate, and the most negative word gives exactly -half.

The frequency word is loaded through a write strobe. It can only be written; the accumulator cannot be read back. Instead, the three top bits of the accumulator select one of eight coarse phase sectors. Each sector yields a 2-bit signed sine level and a 2-bit signed cosine level, with cosine leading sine by a quarter turn. During channel initialisation, a clear request zeroes the accumulator at the next strobe. This happens only if the separate permission input is high when the request is made.

Top module: `carrier_nco`

## Requirements
- R1: While reset is low, the accumulator is zero, `upd_tick` is low, `sin_lvl` is 2'b00 and `cos_lvl` is 2'b01.
- R2: `upd_tick` is high for exactly one clock in every DIV_RATIO clocks. After reset is released, its first high cycle is clock number DIV_RATIO-1, counting from 0.
- R3: On each clock edge where `upd_tick` is high, the accumulator takes accumulator + frequency word. The word is read as two's complement, and the sum wraps modulo 2^PHASE_W.
- R4: On edges where `upd_tick` is low, the accumulator does not change.
- R5: A word written with `freq_wr` is used from the first strobe edge that comes after the write edge. A write on the strobe edge itself takes effect only at the following strobe.
- R6: If `clr_req` and `clr_allow` are both high on an edge, the accumulator becomes zero at the next strobe edge. That strobe may be the same edge. The request is remembered until that strobe, and the clear overrides the addition.
- R7: A `clr_req` made while `clr_allow` is low has no effect on the accumulator.
- R8: Let k be the accumulator's top 3 bits. The sine level is 0 for k=0 and k=4, +1 (2'b01) for k=1..3, and -1 (2'b11) for k=5..7. The cosine level is the sine level of (k+2) mod 8.
- R9: Neither level output ever shows the code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_wr | input | 1 | Write strobe for the frequency word |
| freq_word | input | PHASE_W | Signed frequency word |
| clr_req | input | 1 | Request to clear the phase accumulator |
| clr_allow | input | 1 | Permission for a clear request |
| upd_tick | output | 1 | One-cycle update strobe |
| sin_lvl | output | 2 | Signed sine level |
| cos_lvl | output | 2 | Signed cosine level |

## Verification
The bench builds the block with PHASE_W=6 and DIV_RATIO=5. With these values, every one of the 64 frequency words can be swept from a cleared phase across several strobes, including both extreme words and the wrap of the accumulator. A cycle-accurate arithmetic model in the bench predicts the strobe and both levels on every clock. The short divider also makes it cheap to aim a write, and a clear with or without permission, at the exact strobe edge.

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int PHASE_W   = 18,
  parameter int DIV_RATIO = 62
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freq_wr,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic               clr_req,
  input  logic               clr_allow,
  output logic               upd_tick,
  output logic [1:0]         sin_lvl,
  output logic [1:0]         cos_lvl
);
  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic [CNT_W-1:0]   div_cnt;
  logic [PHASE_W-1:0] freq_q;
  logic [PHASE_W-1:0] phase_acc;
  logic               clr_pend;
  logic               clr_hit;
  logic [2:0]         sector;

  assign upd_tick = (div_cnt == CNT_W'(DIV_RATIO - 1));
  assign clr_hit  = clr_pend | (clr_req & clr_allow);
  assign sector   = phase_acc[PHASE_W-1 -: 3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      freq_q    <= '0;
      phase_acc <= '0;
      clr_pend  <= 1'b0;
    end else begin
      div_cnt <= upd_tick ? '0 : div_cnt + 1'b1;
      if (freq_wr) freq_q <= freq_word;
      if (upd_tick) begin
        phase_acc <= clr_hit ? '0 : phase_acc + freq_q;
        clr_pend  <= 1'b0;
      end else if (clr_req && clr_allow) begin
        clr_pend <= 1'b1;
      end
    end
  end

  function automatic logic [1:0] level(input logic [2:0] k);
    if (k[1:0] == 2'd0) return 2'b00;
    return k[2] ? 2'b11 : 2'b01;
  endfunction

  assign sin_lvl = level(sector);
  assign cos_lvl = level(3'(sector + 3'd2));

  logic [CNT_W:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) gap_cnt <= '0;
    else        gap_cnt <= upd_tick ? '0 : gap_cnt + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (phase_acc == '0 && sin_lvl == 2'b00 && cos_lvl == 2'b01));

  assert_tick_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_RATIO > 1 && upd_tick) |=> !upd_tick);

  assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |-> (gap_cnt == (CNT_W+1)'(DIV_RATIO - 1)));

  assert_acc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && !clr_pend && !(clr_req && clr_allow)) |=>
      (phase_acc == PHASE_W'($past(phase_acc) + $past(freq_q))));

  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> $stable(phase_acc));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && clr_pend) |=> (phase_acc == '0));

  assert_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_allow && !clr_pend) |=> !clr_pend);

  assert_quadrature_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sin_lvl == 2'b00 && cos_lvl == 2'b00));

  assert_level_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_lvl != 2'b10 && cos_lvl != 2'b10));
endmodule

// File: tb/carrier_nco_tb_top.sv
module carrier_nco_tb_top;
  localparam int PW  = 6;
  localparam int DIV = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          freq_wr;
  logic [PW-1:0] freq_word;
  logic          clr_req;
  logic          clr_allow;
  logic          upd_tick;
  logic [1:0]    sin_lvl;
  logic [1:0]    cos_lvl;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  string tag = "R3 R4 R8";

  carrier_nco #(.PHASE_W(PW), .DIV_RATIO(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_word(freq_word),
    .clr_req(clr_req), .clr_allow(clr_allow), .upd_tick(upd_tick),
    .sin_lvl(sin_lvl), .cos_lvl(cos_lvl));

  always #2 clk = ~clk;

  int m_cnt, m_freq, m_acc;
  bit m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_freq = 0; m_acc = 0; m_pend = 0;
    end else begin
      bit tk;
      bit want;
      tk   = (m_cnt == DIV - 1);
      want = clr_req && clr_allow;
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) begin
        m_acc  = (m_pend || want) ? 0 : (m_acc + m_freq) % (1 << PW);
        m_pend = 0;
      end else if (want) begin
        m_pend = 1;
      end
      if (freq_wr) m_freq = freq_word;
    end
  end

  function automatic logic [1:0] exp_level(input int k);
    int kk;
    kk = k % 8;
    if (kk % 4 == 0) return 2'b00;
    return (kk < 4) ? 2'b01 : 2'b11;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int k;
      k = m_acc >> (PW - 3);
      check("R2", {1'b0, upd_tick}, {1'b0, m_cnt == DIV - 1});
      check({tag, " sin"}, sin_lvl, exp_level(k));
      check({tag, " cos"}, cos_lvl, exp_level(k + 2));
      check("R9", {1'b0, sin_lvl == 2'b10 || cos_lvl == 2'b10}, 2'b00);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; freq_wr = 1'b0; freq_word = '0; clr_req = 1'b0; clr_allow = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tick", {1'b0, upd_tick}, 2'b00);
    check("R1 sin", sin_lvl, 2'b00);
    check("R1 cos", cos_lvl, 2'b01);
    rst_n = 1'b1;
    chk_en = 1'b1;

    tag = "R3 R4 R8";
    for (int f = 0; f < (1 << PW); f++) begin
      @(negedge clk);
      freq_wr = 1'b1; freq_word = PW'(f); clr_req = 1'b1; clr_allow = 1'b1;
      @(negedge clk);
      freq_wr = 1'b0; clr_req = 1'b0; clr_allow = 1'b0;
      repeat (4 * DIV) @(negedge clk);
    end

    tag = "R5";
    while (m_cnt != DIV - 1) @(negedge clk);
    freq_wr = 1'b1; freq_word = PW'(7);
    @(negedge clk);
    freq_wr = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    while (m_cnt != 2) @(negedge clk);
    freq_wr = 1'b1; freq_word = PW'(13);
    @(negedge clk);
    freq_wr = 1'b0;
    repeat (3 * DIV) @(negedge clk);

    tag = "R6";
    while (m_cnt != 0) @(negedge clk);
    clr_req = 1'b1; clr_allow = 1'b1;
    @(negedge clk);
    clr_req = 1'b0; clr_allow = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    while (m_cnt != DIV - 1) @(negedge clk);
    clr_req = 1'b1; clr_allow = 1'b1;
    @(negedge clk);
    clr_req = 1'b0; clr_allow = 1'b0;
    check("R6 sector", sin_lvl, 2'b00);
    repeat (2 * DIV) @(negedge clk);

    tag = "R7";
    freq_wr = 1'b1; freq_word = PW'(9);
    @(negedge clk);
    freq_wr = 1'b0; clr_req = 1'b1; clr_allow = 1'b0;
    repeat (6 * DIV) @(negedge clk);
    clr_req = 1'b0;
    repeat (2 * DIV) @(negedge clk);

    chk_en = 1'b0;
    finish_run();
  end
endmodule